// File: doc/BRIEF.md
# Multi-port SDRAM bank-lookahead command scheduler

This block sits between four request ports and an SDRAM command bus. Each port presents one request at a time: a bank, a row, a column and a direction. The request stays asserted until the port sees its grant. The scheduler keeps its own record of which row is open in each bank. It has a separate down-counter for each timing rule in each bank, plus a pair of counters for the shared data bus. Every clock it issues exactly one command: no-operation, precharge, activate, read or write.

The main idea is lookahead. While the data bus is occupied by a burst in one bank, the idle command slots are used to precharge and activate other banks for the requests waiting on them. The row-open delays are then hidden behind data transfer. Column commands to already-open rows are packed a burst length apart, so the read data of consecutive bursts runs with no gap. Once the scheduler has begun preparing a bank for a port, that bank belongs to that port until the port's column command goes out. Later requests for the same bank wait, whatever the rotation order would have said.

Read data is modelled as arriving CL cycles after the READ and lasting BL cycles. Write data is modelled as following the WRITE by one cycle and also lasting BL cycles.

Top module: `sdram_lookahead_sched`

## Requirements
- R1: After reset, cmd_o is NOP (0) and grant_o is all zeros.
- R2: Exactly one command code appears on cmd_o per cycle, encoded NOP=0, PRE=1, ACT=2, RD=3, WR=4. Codes 5 to 7 never appear. When no request is eligible, the cycle carries NOP with no grant. cmd_addr_o carries the row on ACT and the column, zero-extended, on RD and WR.
- R3: An ACT goes only to a bank that has no open row, and no sooner than TRP cycles after the last PRE to that bank.
- R4: A RD or WR goes only to a bank whose open row equals the granted request's row, and no sooner than TRCD cycles after that bank's ACT.
- R5: Two column commands are at least BL cycles apart. A WR that follows a RD is at least BL+CL cycles after it. A RD or WR to an open row is issued as soon as these limits allow: reads back to back come exactly BL cycles apart, which is CL cycles before the previous burst's data ends. A write after a read comes exactly BL+CL cycles after it.
- R6: grant_o is one-hot for exactly the cycle that carries RD or WR, and zero otherwise. The granted port's bank, column and direction match cmd_bank_o, cmd_addr_o and the command, where WR means write.
- R7: While a burst occupies the data bus, PRE and ACT for a different bank are issued in the free slots. With TRP+TRCD+1 <= BL, a miss in another bank gets its column command exactly BL cycles after the current one.
- R8: Four simultaneous reads to four different banks whose rows are open are issued exactly BL cycles apart.
- R9: Once a PRE or ACT has been issued on a bank for a port, no other port is served on that bank until that port is granted. A later request for the same bank does not overtake it, even when the rotation favours it.
- R10: When a column command and a bank-preparation command are both eligible in a cycle, the column command is issued.
- R11: Every request is granted within 400 cycles, for every mapping of the four ports onto the four banks.
- R12: A PRE goes only to a bank with an open row, and no sooner than BL cycles after the last column command to that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPORT | Request pending for each port, held until granted |
| req_write | input | NPORT | Request direction for each port, 1 = write |
| req_bank | input | NPORT*BANK_W | Target bank for each port, packed with port 0 in the low bits |
| req_row | input | NPORT*ROW_W | Target row for each port, packed |
| req_col | input | NPORT*COL_W | Target column for each port, packed |
| cmd_o | output | 3 | Command code (NOP=0, PRE=1, ACT=2, RD=3, WR=4) |
| cmd_bank_o | output | BANK_W | Bank addressed by the command |
| cmd_addr_o | output | ADDR_W | Row on ACT, column on RD and WR, zero otherwise |
| grant_o | output | NPORT | One-cycle grant to the port whose column command is issued |

## Verification
A stale open-row record shows up within a single command. Either an ACT lands on a bank that still has a row open, or a column command goes to a row that was never opened, and a model of the bank state rebuilt from the command stream alone catches both. A bank or bus counter that loads one cycle short shows up at the next command to that bank as a spacing violation. One that loads too long shows up as a gap larger than BL in the back-to-back and hidden-miss scenarios. A lost or wrongly kept bank claim shows up as a wrong grant order, or as a port never granted within the drain limit.

// File: rtl/sdsched_pkg.sv
package sdsched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  // Down-counter load value that permits the next event 'cycles' clocks later.
  function automatic int unsigned cycles_to_load(input int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdsched_rr_pick.sv
module sdsched_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Scan from the highest offset down, so the lowest offset from ptr wins.
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(ptr) + k) % N;
      if (req[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

endmodule

// File: rtl/sdsched_bank.sv
module sdsched_bank
  import sdsched_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int PORT_W = 2,
  parameter int CNT_W  = 4,
  parameter int TRP    = 2,
  parameter int TRCD   = 2,
  parameter int BL     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_i,
  input  logic              act_i,
  input  logic              cas_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              lock_set_i,
  input  logic [PORT_W-1:0] lock_port_i,
  input  logic              lock_clr_i,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              act_ok_o,
  output logic              cas_ok_o,
  output logic              pre_ok_o,
  output logic              locked_o,
  output logic [PORT_W-1:0] owner_o
);

  logic [CNT_W-1:0] trp_c, trcd_c, busy_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o   <= 1'b0;
      row_o    <= '0;
      trp_c    <= '0;
      trcd_c   <= '0;
      busy_c   <= '0;
      locked_o <= 1'b0;
      owner_o  <= '0;
    end else begin
      if (pre_i) begin
        open_o <= 1'b0;
        trp_c  <= CNT_W'(cycles_to_load(TRP));
      end else if (trp_c != '0) begin
        trp_c <= trp_c - 1'b1;
      end

      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        trcd_c <= CNT_W'(cycles_to_load(TRCD));
      end else if (trcd_c != '0) begin
        trcd_c <= trcd_c - 1'b1;
      end

      if (cas_i) begin
        busy_c <= CNT_W'(cycles_to_load(BL));
      end else if (busy_c != '0) begin
        busy_c <= busy_c - 1'b1;
      end

      if (lock_clr_i) begin
        locked_o <= 1'b0;
      end else if (lock_set_i) begin
        locked_o <= 1'b1;
        owner_o  <= lock_port_i;
      end
    end
  end

  assign act_ok_o = !open_o && (trp_c == '0);
  assign cas_ok_o = open_o && (trcd_c == '0);
  assign pre_ok_o = open_o && (trcd_c == '0) && (busy_c == '0);

endmodule

// File: rtl/sdsched_bus.sv
module sdsched_bus
  import sdsched_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BL    = 8,
  parameter int CL    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  output logic rd_ok_o,
  output logic wr_ok_o
);

  logic [CNT_W-1:0] gap_c, turn_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_c  <= '0;
      turn_c <= '0;
    end else begin
      if (rd_i || wr_i) begin
        gap_c <= CNT_W'(cycles_to_load(BL));
      end else if (gap_c != '0) begin
        gap_c <= gap_c - 1'b1;
      end

      if (rd_i) begin
        turn_c <= CNT_W'(cycles_to_load(BL + CL));
      end else if (turn_c != '0) begin
        turn_c <= turn_c - 1'b1;
      end
    end
  end

  assign rd_ok_o = (gap_c == '0);
  assign wr_ok_o = (gap_c == '0) && (turn_c == '0);

endmodule

// File: rtl/sdram_lookahead_sched.sv
module sdram_lookahead_sched
  import sdsched_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TRP   = 2,
  parameter int TRCD  = 2,
  parameter int CL    = 2,
  parameter int BL    = 8,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int MAXT   = max2(max2(TRP, TRCD), BL + CL),
  localparam int CNT_W  = $clog2(MAXT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          req_valid,
  input  logic [NPORT-1:0]          req_write,
  input  logic [NPORT*BANK_W-1:0]   req_bank,
  input  logic [NPORT*ROW_W-1:0]    req_row,
  input  logic [NPORT*COL_W-1:0]    req_col,
  output logic [2:0]                cmd_o,
  output logic [BANK_W-1:0]         cmd_bank_o,
  output logic [ADDR_W-1:0]         cmd_addr_o,
  output logic [NPORT-1:0]          grant_o
);

  // Unpacked view of the requests.
  logic [BANK_W-1:0] pbank [NPORT];
  logic [ROW_W-1:0]  prow  [NPORT];
  logic [COL_W-1:0]  pcol  [NPORT];

  // Per-bank state brought out as named wires.
  logic              b_open   [NBANK];
  logic [ROW_W-1:0]  b_row    [NBANK];
  logic              b_act_ok [NBANK];
  logic              b_cas_ok [NBANK];
  logic              b_pre_ok [NBANK];
  logic              b_locked [NBANK];
  logic [PORT_W-1:0] b_owner  [NBANK];

  logic rd_ok, wr_ok;

  // Per-port classification.
  logic [NPORT-1:0] hit, cas_rdy, need_pre, need_act, prep_rdy;

  // Picker results and rotation pointer.
  logic              cas_found, prep_found;
  logic [PORT_W-1:0] cas_idx, prep_idx, rr_ptr;

  // Next command.
  cmd_e              nxt_cmd;
  logic [BANK_W-1:0] nxt_bank;
  logic [ADDR_W-1:0] nxt_addr;
  logic [NPORT-1:0]  nxt_grant;

  // Issue events.
  logic issue_pre, issue_act, issue_rd, issue_wr;
  logic [NBANK-1:0] ev_pre, ev_act, ev_cas, ev_lock;

  cmd_e cmd_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic own_ok;
    logic same_row;
    assign pbank[p]    = req_bank[p*BANK_W +: BANK_W];
    assign prow[p]     = req_row[p*ROW_W +: ROW_W];
    assign pcol[p]     = req_col[p*COL_W +: COL_W];
    assign own_ok      = !b_locked[pbank[p]] || (b_owner[pbank[p]] == PORT_W'(p));
    assign same_row    = (b_row[pbank[p]] == prow[p]);
    assign hit[p]      = req_valid[p] && own_ok && b_open[pbank[p]] && same_row;
    assign cas_rdy[p]  = hit[p] && b_cas_ok[pbank[p]] && (req_write[p] ? wr_ok : rd_ok);
    assign need_pre[p] = req_valid[p] && own_ok && b_open[pbank[p]] && !same_row
                         && b_pre_ok[pbank[p]];
    assign need_act[p] = req_valid[p] && own_ok && b_act_ok[pbank[p]];
    assign prep_rdy[p] = need_pre[p] || need_act[p];
  end

  sdsched_rr_pick #(.N(NPORT)) u_pick_cas (
    .req   (cas_rdy),
    .ptr   (rr_ptr),
    .found (cas_found),
    .idx   (cas_idx)
  );

  sdsched_rr_pick #(.N(NPORT)) u_pick_prep (
    .req   (prep_rdy),
    .ptr   (rr_ptr),
    .found (prep_found),
    .idx   (prep_idx)
  );

  // Column commands first, then bank preparation, else NOP.
  always_comb begin
    nxt_cmd   = CMD_NOP;
    nxt_bank  = '0;
    nxt_addr  = '0;
    nxt_grant = '0;
    if (cas_found) begin
      nxt_cmd            = req_write[cas_idx] ? CMD_WR : CMD_RD;
      nxt_bank           = pbank[cas_idx];
      nxt_addr           = ADDR_W'(pcol[cas_idx]);
      nxt_grant[cas_idx] = 1'b1;
    end else if (prep_found) begin
      nxt_bank = pbank[prep_idx];
      if (need_pre[prep_idx]) begin
        nxt_cmd = CMD_PRE;
      end else begin
        nxt_cmd  = CMD_ACT;
        nxt_addr = ADDR_W'(prow[prep_idx]);
      end
    end
  end

  assign issue_pre = (nxt_cmd == CMD_PRE);
  assign issue_act = (nxt_cmd == CMD_ACT);
  assign issue_rd  = (nxt_cmd == CMD_RD);
  assign issue_wr  = (nxt_cmd == CMD_WR);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel        = (nxt_bank == BANK_W'(b));
    assign ev_pre[b]  = issue_pre && sel;
    assign ev_act[b]  = issue_act && sel;
    assign ev_cas[b]  = (issue_rd || issue_wr) && sel;
    assign ev_lock[b] = (issue_pre || issue_act) && sel;

    sdsched_bank #(
      .ROW_W  (ROW_W),
      .PORT_W (PORT_W),
      .CNT_W  (CNT_W),
      .TRP    (TRP),
      .TRCD   (TRCD),
      .BL     (BL)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .pre_i       (ev_pre[b]),
      .act_i       (ev_act[b]),
      .cas_i       (ev_cas[b]),
      .row_i       (prow[prep_idx]),
      .lock_set_i  (ev_lock[b]),
      .lock_port_i (prep_idx),
      .lock_clr_i  (ev_cas[b]),
      .open_o      (b_open[b]),
      .row_o       (b_row[b]),
      .act_ok_o    (b_act_ok[b]),
      .cas_ok_o    (b_cas_ok[b]),
      .pre_ok_o    (b_pre_ok[b]),
      .locked_o    (b_locked[b]),
      .owner_o     (b_owner[b])
    );
  end

  sdsched_bus #(
    .CNT_W (CNT_W),
    .BL    (BL),
    .CL    (CL)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (issue_rd),
    .wr_i    (issue_wr),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
      grant_o    <= '0;
      rr_ptr     <= '0;
    end else begin
      cmd_q      <= nxt_cmd;
      cmd_bank_o <= nxt_bank;
      cmd_addr_o <= nxt_addr;
      grant_o    <= nxt_grant;
      if (cas_found) begin
        rr_ptr <= (int'(cas_idx) == NPORT - 1) ? '0 : cas_idx + 1'b1;
      end
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/sdsched_chk.sv
module sdsched_chk
  import sdsched_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int BANK_W = 2,
  parameter int TRP    = 2,
  parameter int TRCD   = 2,
  parameter int BL     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [NPORT-1:0]  grant_o,
  input logic              cas_found,
  input logic              prep_found
);

  logic is_cas;
  assign is_cas = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd4);

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6
  grant_with_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) == is_cas);

  // R10
  cas_before_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_found && prep_found) |=> is_cas);

  if (TRP > 1) begin : g_trp
    // R3
    pre_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_ACT) |-> !($past(cmd_o) == CMD_PRE && $past(cmd_bank_o) == cmd_bank_o));
  end

  if (TRCD > 1) begin : g_trcd
    // R4
    act_cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cas |-> !($past(cmd_o) == CMD_ACT && $past(cmd_bank_o) == cmd_bank_o));
  end

  if (BL > 1) begin : g_bl
    // R5
    cas_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cas |-> !($past(cmd_o) == CMD_RD || $past(cmd_o) == CMD_WR));
  end

endmodule

bind sdram_lookahead_sched sdsched_chk #(
  .NPORT  (NPORT),
  .BANK_W (BANK_W),
  .TRP    (TRP),
  .TRCD   (TRCD),
  .BL     (BL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_o      (cmd_o),
  .cmd_bank_o (cmd_bank_o),
  .grant_o    (grant_o),
  .cas_found  (cas_found),
  .prep_found (prep_found)
);

// File: tb/sdram_lookahead_sched_tb.sv
module sdram_lookahead_sched_tb;

  localparam int NP = 4, NB = 4, RW = 13, CW = 10;
  localparam int TRP = 2, TRCD = 2, CL = 2, BL = 8;
  localparam int AW = 13;
  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_ACT = 3'd2, C_RD = 3'd3, C_WR = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]    req_valid, req_write;
  logic [NP*2-1:0]  req_bank;
  logic [NP*RW-1:0] req_row;
  logic [NP*CW-1:0] req_col;
  logic [2:0]       cmd_o;
  logic [1:0]       cmd_bank_o;
  logic [AW-1:0]    cmd_addr_o;
  logic [NP-1:0]    grant_o;

  // Bench-side request registers.
  logic [NP-1:0] q_v = '0;
  logic [NP-1:0] q_w = '0;
  logic [1:0]    q_b [NP];
  logic [RW-1:0] q_r [NP];
  logic [CW-1:0] q_c [NP];

  always_comb begin
    req_valid = q_v;
    req_write = q_w;
    for (int p = 0; p < NP; p++) begin
      req_bank[p*2 +: 2]   = q_b[p];
      req_row[p*RW +: RW]  = q_r[p];
      req_col[p*CW +: CW]  = q_c[p];
    end
  end

  sdram_lookahead_sched u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .grant_o(grant_o)
  );

  int checks = 0, errors = 0, cyc = 0;

  // Bank model rebuilt from the command stream.
  bit      m_open [NB];
  int      m_row  [NB];
  int      pre_t  [NB];
  int      act_t  [NB];
  int      cas_bt [NB];
  int      last_cas = -1000;
  bit      last_rd  = 1'b0;

  int log_n = 0, act_n = 0;
  int log_p [16];
  int log_t [16];
  int act_r [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic monitor();
    int b, gp;
    b = int'(cmd_bank_o);
    gp = -1;
    for (int k = 0; k < NP; k++) if (grant_o[k]) gp = k;
    case (cmd_o)
      C_NOP: chk(grant_o == '0, "R2 grant on NOP", int'(grant_o), 0);
      C_PRE: begin
        chk(grant_o == '0, "R6 grant on PRE", int'(grant_o), 0);
        chk(m_open[b], "R12 PRE to closed bank", 0, 1);
        chk(cyc - cas_bt[b] >= BL, "R12 PRE after CAS gap", cyc - cas_bt[b], BL);
        m_open[b] = 1'b0;
        pre_t[b] = cyc;
      end
      C_ACT: begin
        chk(grant_o == '0, "R6 grant on ACT", int'(grant_o), 0);
        chk(!m_open[b], "R3 ACT to open bank", 1, 0);
        chk(cyc - pre_t[b] >= TRP, "R3 PRE to ACT gap", cyc - pre_t[b], TRP);
        m_open[b] = 1'b1;
        m_row[b] = int'(cmd_addr_o);
        act_t[b] = cyc;
        if (act_n < 16) begin act_r[act_n] = int'(cmd_addr_o); act_n++; end
      end
      C_RD, C_WR: begin
        chk($countones(grant_o) == 1, "R6 grant onehot", int'(grant_o), 1);
        if (gp >= 0) begin
          chk(q_v[gp], "R6 grant to idle port", gp, -1);
          chk(int'(q_b[gp]) == b, "R6 bank", b, int'(q_b[gp]));
          chk(int'(q_c[gp]) == int'(cmd_addr_o), "R6 column", int'(cmd_addr_o), int'(q_c[gp]));
          chk(q_w[gp] == (cmd_o == C_WR), "R6 direction", int'(cmd_o), q_w[gp] ? 4 : 3);
          chk(m_open[b] && m_row[b] == int'(q_r[gp]), "R4 row open", m_row[b], int'(q_r[gp]));
          q_v[gp] = 1'b0;
          if (log_n < 16) begin log_p[log_n] = gp; log_t[log_n] = cyc; log_n++; end
        end
        chk(cyc - act_t[b] >= TRCD, "R4 ACT to CAS gap", cyc - act_t[b], TRCD);
        chk(cyc - last_cas >= BL, "R5 CAS spacing", cyc - last_cas, BL);
        if (cmd_o == C_WR && last_rd)
          chk(cyc - last_cas >= BL + CL, "R5 read to write gap", cyc - last_cas, BL + CL);
        last_cas = cyc;
        last_rd = (cmd_o == C_RD);
        cas_bt[b] = cyc;
      end
      default: chk(1'b0, "R2 illegal code", int'(cmd_o), 0);
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    monitor();
  endtask

  task automatic post(input int p, input bit w, input int b, input int r, input int c);
    q_w[p] = w;
    q_b[p] = 2'(b);
    q_r[p] = RW'(r);
    q_c[p] = CW'(c);
    q_v[p] = 1'b1;
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while (q_v != '0 && n < 400) begin
      step();
      n++;
    end
    chk(q_v == '0, tag, int'(q_v), 0);
    repeat (BL + CL + 4) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st;
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 1'b0; m_row[b] = 0; pre_t[b] = -1000; act_t[b] = -1000; cas_bt[b] = -1000;
    end
    for (int p = 0; p < NP; p++) begin q_b[p] = '0; q_r[p] = '0; q_c[p] = '0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cmd_o == C_NOP && grant_o == '0, "R1 during reset", int'(cmd_o), 0);
    rst_n = 1'b1;
    step();
    chk(cmd_o == C_NOP, "R1 cmd after reset", int'(cmd_o), 0);
    chk(grant_o == '0, "R1 grant after reset", int'(grant_o), 0);
    // R2: idle cycles carry NOP
    for (int i = 0; i < 4; i++) begin
      step();
      chk(cmd_o == C_NOP, "R2 idle NOP", int'(cmd_o), 0);
    end

    // Open rows 5..8 in banks 0..3.
    for (int p = 0; p < NP; p++) post(p, 1'b0, p, 5 + p, p);
    drain("R11 open phase drained");

    // R8: four hits to four banks, exactly BL apart.
    log_n = 0;
    for (int p = 0; p < NP; p++) post(p, 1'b0, p, 5 + p, 16 + p);
    st = cyc;
    drain("R11 best case drained");
    chk(log_n == 4, "R8 grant count", log_n, 4);
    chk(log_t[0] == st + 1, "R8 first read cycle", log_t[0] - st, 1);
    for (int i = 0; i < 3; i++)
      chk(log_t[i+1] - log_t[i] == BL, "R8 seamless spacing", log_t[i+1] - log_t[i], BL);

    // R7/R10: hit in bank 0 with a miss in bank 1 behind it.
    log_n = 0;
    post(0, 1'b0, 0, 5, 33);
    post(1, 1'b0, 1, 9, 34);
    st = cyc;
    drain("R11 hidden miss drained");
    chk(log_n == 2, "R7 grant count", log_n, 2);
    chk(log_p[0] == 0 && log_t[0] == st + 1, "R10 hit served first", log_p[0], 0);
    chk(log_p[1] == 1, "R7 miss port second", log_p[1], 1);
    chk(log_t[1] - log_t[0] == BL, "R7 miss hidden", log_t[1] - log_t[0], BL);

    // R5: write after read in the same open row.
    log_n = 0;
    post(2, 1'b0, 0, 5, 40);
    st = cyc;
    step();
    chk(log_n == 1 && log_t[0] == st + 1, "R5 read at once", log_n, 1);
    post(3, 1'b1, 0, 5, 41);
    drain("R11 read-write drained");
    chk(log_n == 2 && log_p[1] == 3, "R5 write granted", log_p[1], 3);
    chk(log_t[1] - log_t[0] == BL + CL, "R5 read to write exact", log_t[1] - log_t[0], BL + CL);

    // R9: committed bank is not overtaken (rotation now favours port 0).
    log_n = 0;
    act_n = 0;
    post(2, 1'b0, 0, 7, 50);
    for (int i = 0; i < 20 && cmd_o != C_PRE; i++) step();
    chk(cmd_o == C_PRE, "R9 precharge for port 2", int'(cmd_o), 1);
    post(0, 1'b0, 0, 8, 51);
    drain("R11 commit drained");
    chk(log_n == 2 && log_p[0] == 2, "R9 owner granted first", log_p[0], 2);
    chk(act_n >= 1 && act_r[0] == 7, "R9 owner row opened first", act_r[0], 7);

    // R11: sweep every port-to-bank mapping.
    for (int s = 0; s < 256; s++) begin
      for (int p = 0; p < NP; p++)
        post(p, ((s >> p) & 1) ^ (p & 1), (s >> (2 * p)) & 3, (s + p) % 3, (s & 15) * 4 + p);
      drain("R11 sweep drained");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule